// File: doc/BRIEF.md
# Capability Register File with Access Control

This block holds the capability register state of a processor core that treats every capability as an opaque tagged word. It contains thirty-one general capability registers (numbers 1 to 31), a bank of eight special capabilities reached through a sparse selector, and the program-counter capability chain: current, next and delayed.

Register number 0 has no general storage. It means different things depending on how it is reached. On the plain read port it reads as the null capability, which is all zeros. On the addressing read port it yields the default data capability, which lets address formation fall back to that capability. Writes to number 0 through the general write port are dropped.

Every general access and every selector access is checked against two things: the system-register permission bit of the current program-counter capability, and a call-delay flag. A failed check returns a violation code together with the offending register number, zero-extended to eight bits. The failed access is suppressed: a blocked read returns null and a blocked write changes nothing. Exception entry and exception return reload the next and delayed program-counter capabilities from the kernel code and exception PC special registers.

Top module: `capreg_ctrl`

## Requirements
- R1: The plain read port (`ra_*`) returns all zeros for index 0. For any other index it returns the value stored in that register.
- R2: The addressing read port (`rb_*`) returns the default data capability (selector 0) for index 0. For any other index it returns the same value the plain port would.
- R3: A general write to index 0 has no effect: selector 0 and the addressing port at index 0 keep their old value.
- R4: Selector map: 0 default data, 1 user thread-local, 8 privileged thread-local, 22 and 23 kernel-reserved A and B, 29 kernel code, 30 kernel data, 31 exception PC. Any other selector gives violation code 3 with `sr_vreg` = selector, reads all zeros, and its write is ignored.
- R5: While `call_delay` is 1, index 26 gives violation code 2 with vreg 26. Its read returns zeros and its write is dropped. Other indices are unaffected by the flag.
- R6: When bit `SYSPERM_BIT` (default 10) of the current PC capability is 0, indices 27 to 31 give violation code 1 with vreg equal to the index. The read returns zeros and the write is dropped.
- R7: Every selector except 0 and 1 also needs that permission bit. Without it, the access gives code 1 with vreg equal to the selector, reads zeros and does not write. Selectors 0 and 1 stay accessible.
- R8: After reset, the PC, next-PC, delayed-PC, default data, kernel code and exception PC capabilities hold `DEFAULT_CAP` (all ones). All other special registers and general registers 1 to 31 hold zeros.
- R9: `exc_take` loads next-PC and delayed-PC from kernel code. `exc_return` loads both from exception PC, and `exc_take` wins if both are asserted. `pc_step` loads the PC from delayed-PC.
- R10: Reads are combinational and writes land on the rising clock edge, so a read of the index being written in the same cycle returns the old value. Code 0 means no violation, and vreg is 0 whenever the code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_delay | input | 1 | Call-delay flag guarding index 26 |
| exc_take | input | 1 | Exception entry |
| exc_return | input | 1 | Exception return |
| pc_step | input | 1 | Advance PC from delayed-PC |
| ra_idx | input | 5 | Plain read index |
| ra_data | output | CAP_W | Plain read data |
| ra_vcode | output | 2 | Plain read violation code |
| ra_vreg | output | 8 | Plain read violating register |
| rb_idx | input | 5 | Addressing read index |
| rb_data | output | CAP_W | Addressing read data |
| rb_vcode | output | 2 | Addressing read violation code |
| rb_vreg | output | 8 | Addressing read violating register |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 5 | General write index |
| wr_data | input | CAP_W | General write data |
| wr_vcode | output | 2 | Write violation code |
| wr_vreg | output | 8 | Write violating register |
| sr_sel | input | 5 | Special register selector |
| sr_wr_en | input | 1 | Special register write enable |
| sr_wr_data | input | CAP_W | Special register write data |
| sr_rd_data | output | CAP_W | Special register read data |
| sr_vcode | output | 2 | Selector violation code |
| sr_vreg | output | 8 | Selector violating number |
| pc_cap | output | CAP_W | Current PC capability |
| next_pc_cap | output | CAP_W | Next PC capability |
| delayed_pc_cap | output | CAP_W | Delayed PC capability |

## Verification
The hardest state to reach is a PC capability that lacks the system-register permission. Nothing drives the PC directly, so the stimulus builds it in steps. It first writes a kernel code value with bit 10 clear through selector 29 while the permission still holds. It then takes an exception and steps the PC. The bench then probes indices 27 to 31 and the gated selectors, and confirms that the writes it attempted there were dropped. Finally it restores permission by returning through the exception PC capability, which also shows that the special registers keep their values across the blocked period.

// File: rtl/capreg_pkg.sv
package capreg_pkg;
  localparam int IDX_W  = 5;
  localparam int NREG   = 32;
  localparam int VREG_W = 8;
  localparam int SR_N   = 8;
  localparam logic [IDX_W-1:0] IDX_CALLDATA = IDX_W'(26);
  localparam logic [IDX_W-1:0] IDX_SYS_LO   = IDX_W'(27);

  typedef enum logic [1:0] {
    VC_NONE     = 2'd0,
    VC_SYSREG   = 2'd1,
    VC_CALLDATA = 2'd2,
    VC_BADSEL   = 2'd3
  } vcode_e;

  typedef enum logic [2:0] {
    SR_DDC   = 3'd0,
    SR_UTLS  = 3'd1,
    SR_PTLS  = 3'd2,
    SR_KRESA = 3'd3,
    SR_KRESB = 3'd4,
    SR_KCODE = 3'd5,
    SR_KDATA = 3'd6,
    SR_EPC   = 3'd7
  } sreg_e;

  // {valid, slot}
  function automatic logic [3:0] sel_map(input logic [IDX_W-1:0] sel);
    logic [3:0] r;
    case (sel)
      5'd0:    r = {1'b1, SR_DDC};
      5'd1:    r = {1'b1, SR_UTLS};
      5'd8:    r = {1'b1, SR_PTLS};
      5'd22:   r = {1'b1, SR_KRESA};
      5'd23:   r = {1'b1, SR_KRESB};
      5'd29:   r = {1'b1, SR_KCODE};
      5'd30:   r = {1'b1, SR_KDATA};
      5'd31:   r = {1'b1, SR_EPC};
      default: r = 4'd0;
    endcase
    return r;
  endfunction

  function automatic logic slot_needs_perm(input logic [2:0] slot);
    return !(slot == SR_DDC || slot == SR_UTLS);
  endfunction
endpackage

// File: rtl/capreg_access_check.sv
module capreg_access_check
  import capreg_pkg::*;
(
  input  logic              active,
  input  logic [IDX_W-1:0]  idx,
  input  logic              call_delay,
  input  logic              sysperm,
  output vcode_e            vcode,
  output logic [VREG_W-1:0] vreg
);
  always_comb begin
    vcode = VC_NONE;
    if (active) begin
      if (idx == IDX_CALLDATA && call_delay)
        vcode = VC_CALLDATA;
      else if (idx >= IDX_SYS_LO && !sysperm)
        vcode = VC_SYSREG;
    end
    vreg = (vcode != VC_NONE) ? {{(VREG_W-IDX_W){1'b0}}, idx} : '0;
  end
endmodule

// File: rtl/capreg_gpr_bank.sv
module capreg_gpr_bank
  import capreg_pkg::*;
#(
  parameter int CAP_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CAP_W-1:0] wr_data,
  input  logic [IDX_W-1:0] ra_idx,
  output logic [CAP_W-1:0] ra_data,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [CAP_W-1:0] rb_data
);
  logic [NREG*CAP_W-1:0] flat;

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    if (g == 0) begin : g_zero
      assign flat[g*CAP_W +: CAP_W] = '0;
    end else begin : g_reg
      logic             hit;
      logic [CAP_W-1:0] q;
      assign hit = wr_en && (wr_idx == IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= wr_data;
      end
      assign flat[g*CAP_W +: CAP_W] = q;
    end
  end

  always_comb begin
    ra_data = flat[ra_idx*CAP_W +: CAP_W];
    rb_data = flat[rb_idx*CAP_W +: CAP_W];
  end
endmodule

// File: rtl/capreg_special_bank.sv
module capreg_special_bank
  import capreg_pkg::*;
#(
  parameter int               CAP_W       = 32,
  parameter logic [CAP_W-1:0] DEFAULT_CAP = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  sel,
  input  logic              wr_en,
  input  logic [CAP_W-1:0]  wr_data,
  input  logic              sysperm,
  output logic [CAP_W-1:0]  rd_data,
  output vcode_e            vcode,
  output logic [VREG_W-1:0] vreg,
  output logic [CAP_W-1:0]  ddc,
  output logic [CAP_W-1:0]  kcode,
  output logic [CAP_W-1:0]  epc
);
  logic [3:0]            map;
  logic                  sel_ok;
  logic [2:0]            slot;
  logic                  wr_ok;
  logic [SR_N*CAP_W-1:0] flat;

  assign map    = sel_map(sel);
  assign sel_ok = map[3];
  assign slot   = map[2:0];

  always_comb begin
    if (!sel_ok)
      vcode = VC_BADSEL;
    else if (slot_needs_perm(slot) && !sysperm)
      vcode = VC_SYSREG;
    else
      vcode = VC_NONE;
    vreg  = (vcode != VC_NONE) ? {{(VREG_W-IDX_W){1'b0}}, sel} : '0;
    wr_ok = wr_en && (vcode == VC_NONE);
  end

  for (genvar g = 0; g < SR_N; g++) begin : g_slot
    localparam logic [CAP_W-1:0] RST_V =
      (g == int'(SR_DDC) || g == int'(SR_KCODE) || g == int'(SR_EPC)) ? DEFAULT_CAP : '0;
    logic             hit;
    logic [CAP_W-1:0] q;
    assign hit = wr_ok && (slot == 3'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= RST_V;
      else if (hit) q <= wr_data;
    end
    assign flat[g*CAP_W +: CAP_W] = q;
  end

  assign rd_data = (vcode == VC_NONE) ? flat[int'(slot)*CAP_W +: CAP_W] : '0;
  assign ddc     = flat[int'(SR_DDC)*CAP_W   +: CAP_W];
  assign kcode   = flat[int'(SR_KCODE)*CAP_W +: CAP_W];
  assign epc     = flat[int'(SR_EPC)*CAP_W   +: CAP_W];

  AST_BADSEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel_ok) |=> $stable(flat)); // R4
  AST_GATED_SEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_ok && slot_needs_perm(slot) && !sysperm) |=> $stable(flat)); // R7
endmodule

// File: rtl/capreg_pc_unit.sv
module capreg_pc_unit #(
  parameter int               CAP_W       = 32,
  parameter logic [CAP_W-1:0] DEFAULT_CAP = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exc_take,
  input  logic             exc_return,
  input  logic             pc_step,
  input  logic [CAP_W-1:0] kcode,
  input  logic [CAP_W-1:0] epc,
  output logic [CAP_W-1:0] pc,
  output logic [CAP_W-1:0] next_pc,
  output logic [CAP_W-1:0] delayed_pc
);
  logic [CAP_W-1:0] pc_q, nxt_q, dly_q, pc_d, nxt_d, dly_d;
  logic             redirect;

  always_comb begin
    redirect = exc_take || exc_return;
    nxt_d    = exc_take ? kcode : epc;
    dly_d    = nxt_d;
    pc_d     = dly_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_q <= DEFAULT_CAP;
      dly_q <= DEFAULT_CAP;
    end else if (redirect) begin
      nxt_q <= nxt_d;
      dly_q <= dly_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc_q <= DEFAULT_CAP;
    else if (pc_step) pc_q <= pc_d;
  end

  assign pc         = pc_q;
  assign next_pc    = nxt_q;
  assign delayed_pc = dly_q;

  AST_EXC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> (next_pc == $past(kcode) && delayed_pc == $past(kcode))); // R9
  AST_ERET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return && !exc_take) |=> (next_pc == $past(epc) && delayed_pc == $past(epc))); // R9
endmodule

// File: rtl/capreg_ctrl.sv
module capreg_ctrl
  import capreg_pkg::*;
#(
  parameter int               CAP_W       = 32,
  parameter int               SYSPERM_BIT = 10,
  parameter logic [CAP_W-1:0] DEFAULT_CAP = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_delay,
  input  logic              exc_take,
  input  logic              exc_return,
  input  logic              pc_step,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic [CAP_W-1:0]  ra_data,
  output logic [1:0]        ra_vcode,
  output logic [VREG_W-1:0] ra_vreg,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [CAP_W-1:0]  rb_data,
  output logic [1:0]        rb_vcode,
  output logic [VREG_W-1:0] rb_vreg,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [CAP_W-1:0]  wr_data,
  output logic [1:0]        wr_vcode,
  output logic [VREG_W-1:0] wr_vreg,
  input  logic [IDX_W-1:0]  sr_sel,
  input  logic              sr_wr_en,
  input  logic [CAP_W-1:0]  sr_wr_data,
  output logic [CAP_W-1:0]  sr_rd_data,
  output logic [1:0]        sr_vcode,
  output logic [VREG_W-1:0] sr_vreg,
  output logic [CAP_W-1:0]  pc_cap,
  output logic [CAP_W-1:0]  next_pc_cap,
  output logic [CAP_W-1:0]  delayed_pc_cap
);
  localparam int NPORT = 3; // 0 plain read, 1 addressing read, 2 write

  logic [1:0] rs_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  logic                         sysperm;
  logic [CAP_W-1:0]             ddc, kcode, epc, gpr_ra, gpr_rb;
  logic [NPORT-1:0][IDX_W-1:0]  chk_idx;
  logic [NPORT-1:0]             chk_act;
  vcode_e                       chk_vc [NPORT];
  logic [NPORT-1:0][VREG_W-1:0] chk_vr;
  vcode_e                       sr_vc;
  logic                         wr_ok;

  assign sysperm = pc_cap[SYSPERM_BIT];
  assign chk_idx = {wr_idx, rb_idx, ra_idx};
  assign chk_act = {wr_en, 1'b1, 1'b1};

  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    capreg_access_check u_chk (
      .active     (chk_act[p]),
      .idx        (chk_idx[p]),
      .call_delay (call_delay),
      .sysperm    (sysperm),
      .vcode      (chk_vc[p]),
      .vreg       (chk_vr[p])
    );
  end

  assign wr_ok = wr_en && (chk_vc[2] == VC_NONE);

  capreg_gpr_bank #(.CAP_W(CAP_W)) u_gpr (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .wr_en   (wr_ok),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .ra_idx  (ra_idx),
    .ra_data (gpr_ra),
    .rb_idx  (rb_idx),
    .rb_data (gpr_rb)
  );

  capreg_special_bank #(.CAP_W(CAP_W), .DEFAULT_CAP(DEFAULT_CAP)) u_spec (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .sel     (sr_sel),
    .wr_en   (sr_wr_en),
    .wr_data (sr_wr_data),
    .sysperm (sysperm),
    .rd_data (sr_rd_data),
    .vcode   (sr_vc),
    .vreg    (sr_vreg),
    .ddc     (ddc),
    .kcode   (kcode),
    .epc     (epc)
  );

  capreg_pc_unit #(.CAP_W(CAP_W), .DEFAULT_CAP(DEFAULT_CAP)) u_pc (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .exc_take   (exc_take),
    .exc_return (exc_return),
    .pc_step    (pc_step),
    .kcode      (kcode),
    .epc        (epc),
    .pc         (pc_cap),
    .next_pc    (next_pc_cap),
    .delayed_pc (delayed_pc_cap)
  );

  always_comb begin
    ra_data  = (chk_vc[0] != VC_NONE) ? '0 : gpr_ra;
    if (chk_vc[1] != VC_NONE)   rb_data = '0;
    else if (rb_idx == '0)      rb_data = ddc;
    else                        rb_data = gpr_rb;
    ra_vcode = chk_vc[0];
    rb_vcode = chk_vc[1];
    wr_vcode = chk_vc[2];
    sr_vcode = sr_vc;
    ra_vreg  = chk_vr[0];
    rb_vreg  = chk_vr[1];
    wr_vreg  = chk_vr[2];
  end

  AST_IDX0_NULL: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ra_idx == '0) |-> (ra_data == '0)); // R1
  AST_IDX0_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_en && wr_idx == '0 && !sr_wr_en) |=> $stable(ddc)); // R3
  AST_CALLDELAY_BLOCK: assert property (@(posedge clk) disable iff (!rst_s_n)
    (call_delay && ra_idx == IDX_CALLDATA) |-> (ra_data == '0 && ra_vcode == VC_CALLDATA)); // R5
  AST_SYSPERM_BLOCK: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!sysperm && rb_idx >= IDX_SYS_LO) |-> (rb_data == '0 && rb_vcode == VC_SYSREG)); // R6
endmodule

// File: tb/capreg_ctrl_test.sv
module capreg_ctrl_test;
  localparam logic [31:0] DEF = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        call_delay = 0, exc_take = 0, exc_return = 0, pc_step = 0;
  logic [4:0]  ra_idx = 0, rb_idx = 0, wr_idx = 0, sr_sel = 0;
  logic        wr_en = 0, sr_wr_en = 0;
  logic [31:0] wr_data = 0, sr_wr_data = 0;
  logic [31:0] ra_data, rb_data, sr_rd_data, pc_cap, next_pc_cap, delayed_pc_cap;
  logic [1:0]  ra_vcode, rb_vcode, wr_vcode, sr_vcode;
  logic [7:0]  ra_vreg, rb_vreg, wr_vreg, sr_vreg;

  always #10 clk = ~clk;

  capreg_ctrl uut (
    .clk(clk), .rst_n(rst_n), .call_delay(call_delay), .exc_take(exc_take),
    .exc_return(exc_return), .pc_step(pc_step),
    .ra_idx(ra_idx), .ra_data(ra_data), .ra_vcode(ra_vcode), .ra_vreg(ra_vreg),
    .rb_idx(rb_idx), .rb_data(rb_data), .rb_vcode(rb_vcode), .rb_vreg(rb_vreg),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_vcode(wr_vcode), .wr_vreg(wr_vreg),
    .sr_sel(sr_sel), .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
    .sr_rd_data(sr_rd_data), .sr_vcode(sr_vcode), .sr_vreg(sr_vreg),
    .pc_cap(pc_cap), .next_pc_cap(next_pc_cap), .delayed_pc_cap(delayed_pc_cap)
  );

  typedef enum int {P_RA, P_RB, P_SR, P_RAVC, P_RBVC, P_WRVC, P_SRVC,
                    P_PC, P_NPC, P_DPC, P_RAVR, P_SRVR, P_WRVR} port_e;
  typedef struct { port_e port; logic [31:0] exp; string tag; } item_t;

  item_t sb[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  function automatic logic [31:0] observe(port_e p);
    case (p)
      P_RA:    return ra_data;
      P_RB:    return rb_data;
      P_SR:    return sr_rd_data;
      P_RAVC:  return 32'(ra_vcode);
      P_RBVC:  return 32'(rb_vcode);
      P_WRVC:  return 32'(wr_vcode);
      P_SRVC:  return 32'(sr_vcode);
      P_PC:    return pc_cap;
      P_NPC:   return next_pc_cap;
      P_DPC:   return delayed_pc_cap;
      P_RAVR:  return 32'(ra_vreg);
      P_SRVR:  return 32'(sr_vreg);
      default: return 32'(wr_vreg);
    endcase
  endfunction

  task automatic expect_item(port_e p, logic [31:0] v, string tag);
    item_t it;
    it.port = p; it.exp = v; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: samples a quarter period after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = sb.pop_front();
        act = observe(it.port);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s port %s actual %h expected %h", it.tag, it.port.name(), act, it.exp);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    wr_en = 0; sr_wr_en = 0; exc_take = 0; exc_return = 0; pc_step = 0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int sels [6] = '{1, 8, 22, 23, 30, 31};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();

    // R8 reset state
    ra_idx = 5; rb_idx = 0; sr_sel = 0;
    expect_item(P_RA, 32'h0, "R8"); expect_item(P_RB, DEF, "R8");
    expect_item(P_SR, DEF, "R8");
    expect_item(P_PC, DEF, "R8"); expect_item(P_NPC, DEF, "R8"); expect_item(P_DPC, DEF, "R8");
    expect_item(P_RAVC, 0, "R10"); expect_item(P_RAVR, 0, "R10");
    for (int i = 0; i < 6; i++) begin
      tick(); sr_sel = 5'(sels[i]);
      expect_item(P_SR, (sels[i] == 31) ? DEF : 32'h0, "R8");
    end
    tick(); sr_sel = 29; expect_item(P_SR, DEF, "R8");

    // R10 write timing, same-cycle read sees old value
    tick(); wr_en = 1; wr_idx = 5; wr_data = 32'hA5A5_0005; ra_idx = 5;
    expect_item(P_RA, 32'h0, "R10");
    tick(); ra_idx = 5; rb_idx = 5;
    expect_item(P_RA, 32'hA5A5_0005, "R10"); expect_item(P_RB, 32'hA5A5_0005, "R2");

    // fill and read back all general registers
    for (int i = 1; i < 32; i++) begin
      tick(); wr_en = 1; wr_idx = 5'(i); wr_data = 32'h100 + i;
    end
    for (int i = 0; i < 32; i++) begin
      tick(); ra_idx = 5'(i); rb_idx = 5'(i);
      expect_item(P_RA, (i == 0) ? 32'h0 : 32'h100 + i, "R1");
      expect_item(P_RB, (i == 0) ? DEF : 32'h100 + i, "R2");
    end

    // R3 write to index 0
    tick(); wr_en = 1; wr_idx = 0; wr_data = 32'h1234;
    tick(); rb_idx = 0; sr_sel = 0; ra_idx = 0;
    expect_item(P_RB, DEF, "R3"); expect_item(P_SR, DEF, "R3"); expect_item(P_RA, 0, "R3");

    // selector write to default data, seen on addressing port
    tick(); sr_wr_en = 1; sr_sel = 0; sr_wr_data = 32'hD0D0;
    tick(); rb_idx = 0; ra_idx = 0;
    expect_item(P_RB, 32'hD0D0, "R2"); expect_item(P_RA, 0, "R1");

    // R4 selector map
    for (int i = 0; i < 6; i++) begin
      tick(); sr_wr_en = 1; sr_sel = 5'(sels[i]); sr_wr_data = 32'h5000_0400 + sels[i];
    end
    for (int i = 0; i < 6; i++) begin
      tick(); sr_sel = 5'(sels[i]);
      expect_item(P_SR, 32'h5000_0400 + sels[i], "R4"); expect_item(P_SRVC, 0, "R4");
    end
    tick(); sr_sel = 5;
    expect_item(P_SRVC, 3, "R4"); expect_item(P_SRVR, 5, "R4"); expect_item(P_SR, 0, "R4");
    tick(); sr_wr_en = 1; sr_sel = 5; sr_wr_data = 32'hEEEE;
    tick(); sr_sel = 1; expect_item(P_SR, 32'h5000_0401, "R4");
    tick(); sr_sel = 8; expect_item(P_SR, 32'h5000_0408, "R4");

    // R5 call delay
    call_delay = 1;
    tick(); ra_idx = 26; wr_en = 1; wr_idx = 26; wr_data = 32'hBAD;
    expect_item(P_RA, 0, "R5"); expect_item(P_RAVC, 2, "R5"); expect_item(P_RAVR, 26, "R5");
    expect_item(P_WRVC, 2, "R5"); expect_item(P_WRVR, 26, "R5");
    tick(); ra_idx = 27; expect_item(P_RA, 32'h11B, "R5"); expect_item(P_RAVC, 0, "R5");
    call_delay = 0;
    tick(); ra_idx = 26; expect_item(P_RA, 32'h11A, "R5");

    // R9 exception path, dropping the permission
    tick(); sr_wr_en = 1; sr_sel = 29; sr_wr_data = 32'hFFFF_FBFF;
    tick(); sr_sel = 29; expect_item(P_SR, 32'hFFFF_FBFF, "R4"); exc_take = 1;
    tick(); expect_item(P_NPC, 32'hFFFF_FBFF, "R9"); expect_item(P_DPC, 32'hFFFF_FBFF, "R9");
    expect_item(P_PC, DEF, "R9"); pc_step = 1;
    tick(); expect_item(P_PC, 32'hFFFF_FBFF, "R9");

    // R6 / R7 without permission
    tick(); ra_idx = 27; rb_idx = 31; wr_en = 1; wr_idx = 28; wr_data = 32'hBAD; sr_sel = 8;
    expect_item(P_RA, 0, "R6"); expect_item(P_RAVC, 1, "R6"); expect_item(P_RAVR, 27, "R6");
    expect_item(P_RB, 0, "R6"); expect_item(P_RBVC, 1, "R6");
    expect_item(P_WRVC, 1, "R6"); expect_item(P_WRVR, 28, "R6");
    expect_item(P_SRVC, 1, "R7"); expect_item(P_SRVR, 8, "R7"); expect_item(P_SR, 0, "R7");
    tick(); sr_sel = 0; ra_idx = 26;
    expect_item(P_SR, 32'hD0D0, "R7"); expect_item(P_SRVC, 0, "R7");
    expect_item(P_RA, 32'h11A, "R6");
    tick(); sr_wr_en = 1; sr_sel = 30; sr_wr_data = 32'h77;
    tick(); sr_sel = 1; expect_item(P_SR, 32'h5000_0401, "R7");

    // R9 return restores permission
    tick(); exc_return = 1;
    tick(); expect_item(P_NPC, 32'h5000_041F, "R9"); expect_item(P_DPC, 32'h5000_041F, "R9");
    pc_step = 1;
    tick(); expect_item(P_PC, 32'h5000_041F, "R9");
    ra_idx = 28; sr_sel = 30;
    expect_item(P_RA, 32'h11C, "R6"); expect_item(P_SR, 32'h5000_041E, "R7");

    // R9 both requests at once: entry wins
    tick(); exc_take = 1; exc_return = 1;
    tick(); expect_item(P_NPC, 32'hFFFF_FBFF, "R9");

    tick(); tick();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule